// File: doc/BRIEF.md
# Byte-Lane I/O Port Decoder

This block is a bank of peripheral port registers in the I/O space of a 16-bit processor bus. The bus presents a 16-bit port address whose bit 0 marks the low or high byte, an active-low byte-high-enable, separate read and write strobes and a 16-bit data path. The bank holds a number of byte-port pairs and a number of word ports. In each pair the even-addressed port lives on data bits 7:0 and the odd-addressed port lives on data bits 15:8. Each port gets its own chip select.

Every chip select is qualified by the lane conditions. Address bit 0 gates the low lane and the byte-high-enable gates the high lane. A byte write to one port of a pair therefore never lands in its neighbour. Word ports respond only to full-word cycles at even addresses. Reads are combinational. The read data carries the selected port contents on the selected lanes and zero everywhere else.

The strobes are level signals sampled once per clock. A write completes in the cycle it is presented, so the block has no back-pressure and no ready signal. The bus owner may hold or change the inputs on any cycle.

Top module: `ioport_lane_bank`

## Requirements
- R1: Low-lane byte port k sits at address BYTE_BASE+2k (BYTE_BASE even). It is selected only when address bit 0 is 0, and it reads and writes data bits 7:0.
- R2: High-lane byte port k sits at address BYTE_BASE+2k+1. It is selected only when bhe_n is 0, and it reads and writes data bits 15:8. A cycle with address bit 0 = 1 and bhe_n = 0 (including a word access at an odd address) selects only that odd port.
- R3: A cycle at BYTE_BASE+2k with address bit 0 = 0 and bhe_n = 0 selects both ports of pair k. Bits 7:0 go to the even port and bits 15:8 go to the odd port.
- R4: Word port k sits at address WORD_BASE+2k (even). It is selected only when address bit 0 = 0 and bhe_n = 0. A byte access to it asserts no chip select and leaves its contents unchanged.
- R5: A cycle with address bit 0 = 1 and bhe_n = 1 is invalid. It asserts no chip select, changes no port, and reads as zero.
- R6: Reset (rst_n low) clears every port register to zero.
- R7: A write updates only the selected lanes of the selected port, at the rising clock edge while wr_en is 1. Ports not selected keep their value.
- R8: While rd_en is 1, rdata carries the selected port data on the selected lanes, in the same cycle. Unselected lanes read as zero, and an address that matches no port reads as zero. While rd_en is 0, rdata is zero.
- R9: cs has this layout: bits [NB-1:0] are the low-lane byte ports, bits [2NB-1:NB] are the high-lane byte ports, and bits [2NB+NW-1:2NB] are the word ports, where NB = N_BYTE_PAIRS and NW = N_WORD. A chip select is asserted only while rd_en or wr_en is 1, and at most one bit per group is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all ports |
| addr | input | 16 | Port address; bit 0 is the lane bit |
| bhe_n | input | 1 | Byte-high-enable, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data, both lanes |
| rdata | output | 16 | Read data, zero on lanes not selected |
| cs | output | 2*N_BYTE_PAIRS+N_WORD | Per-port chip selects |

## Verification
The hardest case to reach is interference between the two ports of one pair. A byte write to one port has to be followed by a read of the other, with invalid and odd-word cycles mixed in between. Uniform random addresses almost never land inside the small port windows. The random stimulus therefore draws most addresses from the byte-pair and word windows, with all four combinations of address bit 0 and bhe_n. Directed cycles write each lane of a pair alone and then read the pair back as a word.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
  } lane_sel_t;

  function automatic lane_sel_t lanes_of(input logic a0, input logic bhe_n);
    lane_sel_t l;
    l.lo = ~a0;
    l.hi = ~bhe_n;
    return l;
  endfunction

  function automatic logic is_full_word(input lane_sel_t l);
    return l.lo & l.hi;
  endfunction
endpackage

// File: rtl/ioport_addr_decode.sv
module ioport_addr_decode
  import ioport_pkg::*;
#(
  parameter int          N_BYTE_PAIRS = 4,
  parameter int          N_WORD       = 2,
  parameter logic [15:0] BYTE_BASE    = 16'h0040,
  parameter logic [15:0] WORD_BASE    = 16'h0080
) (
  input  logic [15:0]             addr,
  input  logic                    bhe_n,
  input  logic                    access,
  output logic [N_BYTE_PAIRS-1:0] cs_lo,
  output logic [N_BYTE_PAIRS-1:0] cs_hi,
  output logic [N_WORD-1:0]       cs_w
);
  lane_sel_t lanes;
  assign lanes = lanes_of(addr[0], bhe_n);

  for (genvar k = 0; k < N_BYTE_PAIRS; k++) begin : g_pair
    localparam logic [15:0] PAIR_ADDR = BYTE_BASE + 16'(2 * k);
    logic hit;
    assign hit      = access && (addr[15:1] == PAIR_ADDR[15:1]);
    assign cs_lo[k] = hit & lanes.lo;
    assign cs_hi[k] = hit & lanes.hi;
  end

  for (genvar k = 0; k < N_WORD; k++) begin : g_word
    localparam logic [15:0] WADDR = WORD_BASE + 16'(2 * k);
    assign cs_w[k] = access && (addr[15:1] == WADDR[15:1]) && is_full_word(lanes);
  end
endmodule

// File: rtl/ioport_reg.sv
module ioport_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/ioport_read_mux.sv
module ioport_read_mux #(
  parameter int N_BYTE_PAIRS = 4,
  parameter int N_WORD       = 2
) (
  input  logic                         rd_en,
  input  logic [N_BYTE_PAIRS-1:0]      cs_lo,
  input  logic [N_BYTE_PAIRS-1:0]      cs_hi,
  input  logic [N_WORD-1:0]            cs_w,
  input  logic [N_BYTE_PAIRS-1:0][7:0] lo_q,
  input  logic [N_BYTE_PAIRS-1:0][7:0] hi_q,
  input  logic [N_WORD-1:0][15:0]      w_q,
  output logic [15:0]                  rdata
);
  logic [7:0] lane_lo, lane_hi;
  always_comb begin
    lane_lo = '0;
    lane_hi = '0;
    for (int k = 0; k < N_BYTE_PAIRS; k++) begin
      if (cs_lo[k]) lane_lo = lane_lo | lo_q[k];
      if (cs_hi[k]) lane_hi = lane_hi | hi_q[k];
    end
    for (int k = 0; k < N_WORD; k++) begin
      if (cs_w[k]) begin
        lane_lo = lane_lo | w_q[k][7:0];
        lane_hi = lane_hi | w_q[k][15:8];
      end
    end
  end
  assign rdata = rd_en ? {lane_hi, lane_lo} : 16'h0000;
endmodule

// File: rtl/ioport_lane_bank.sv
module ioport_lane_bank #(
  parameter int          N_BYTE_PAIRS = 4,
  parameter int          N_WORD       = 2,
  parameter logic [15:0] BYTE_BASE    = 16'h0040,
  parameter logic [15:0] WORD_BASE    = 16'h0080
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [15:0]                        addr,
  input  logic                               bhe_n,
  input  logic                               wr_en,
  input  logic                               rd_en,
  input  logic [15:0]                        wdata,
  output logic [15:0]                        rdata,
  output logic [2*N_BYTE_PAIRS+N_WORD-1:0]   cs
);
  localparam int NB = N_BYTE_PAIRS;
  localparam int NW = N_WORD;

  logic [NB-1:0]      cs_lo, cs_hi;
  logic [NW-1:0]      cs_w;
  logic [NB-1:0][7:0] lo_q, hi_q;
  logic [NW-1:0][15:0] w_q;

  ioport_addr_decode #(
    .N_BYTE_PAIRS(NB), .N_WORD(NW), .BYTE_BASE(BYTE_BASE), .WORD_BASE(WORD_BASE)
  ) u_dec (
    .addr(addr), .bhe_n(bhe_n), .access(rd_en | wr_en),
    .cs_lo(cs_lo), .cs_hi(cs_hi), .cs_w(cs_w)
  );

  for (genvar k = 0; k < NB; k++) begin : g_byte
    ioport_reg #(.W(8)) u_lo (
      .clk(clk), .rst_n(rst_n), .we(wr_en & cs_lo[k]), .d(wdata[7:0]), .q(lo_q[k])
    );
    ioport_reg #(.W(8)) u_hi (
      .clk(clk), .rst_n(rst_n), .we(wr_en & cs_hi[k]), .d(wdata[15:8]), .q(hi_q[k])
    );
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    ioport_reg #(.W(16)) u_w (
      .clk(clk), .rst_n(rst_n), .we(wr_en & cs_w[k]), .d(wdata), .q(w_q[k])
    );
  end

  ioport_read_mux #(.N_BYTE_PAIRS(NB), .N_WORD(NW)) u_mux (
    .rd_en(rd_en), .cs_lo(cs_lo), .cs_hi(cs_hi), .cs_w(cs_w),
    .lo_q(lo_q), .hi_q(hi_q), .w_q(w_q), .rdata(rdata)
  );

  assign cs = {cs_w, cs_hi, cs_lo};
endmodule

// File: rtl/ioport_lane_bank_chk.sv
module ioport_lane_bank_chk #(
  parameter int N_BYTE_PAIRS = 4,
  parameter int N_WORD       = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [15:0]                      addr,
  input logic                             bhe_n,
  input logic                             wr_en,
  input logic                             rd_en,
  input logic [15:0]                      rdata,
  input logic [2*N_BYTE_PAIRS+N_WORD-1:0] cs
);
  localparam int NB = N_BYTE_PAIRS;
  localparam int NW = N_WORD;

  logic [NB-1:0] c_lo, c_hi;
  logic [NW-1:0] c_w;
  assign c_lo = cs[NB-1:0];
  assign c_hi = cs[2*NB-1:NB];
  assign c_w  = cs[2*NB+NW-1:2*NB];

  a_r1_lo_needs_even: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lo != '0) |-> !addr[0]);
  a_r2_hi_needs_bhe: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hi != '0) |-> !bhe_n);
  a_r4_word_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    (c_w != '0) |-> (!addr[0] && !bhe_n));
  a_r5_invalid_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] && bhe_n) |-> (cs == '0));
  a_r9_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> (cs == '0));
  a_r9_onehot_groups: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(c_lo) && $onehot0(c_hi) && $onehot0(c_w));
  a_r8_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 16'h0000));
  a_r8_lo_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && c_lo == '0 && c_w == '0) |-> (rdata[7:0] == 8'h00));
  a_r8_hi_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && c_hi == '0 && c_w == '0) |-> (rdata[15:8] == 8'h00));
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && !$past(wr_en) && $stable(addr) && $stable(bhe_n))
      |-> $stable(rdata));
endmodule

bind ioport_lane_bank ioport_lane_bank_chk #(
  .N_BYTE_PAIRS(N_BYTE_PAIRS), .N_WORD(N_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .bhe_n(bhe_n), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .cs(cs)
);

// File: tb/ioport_lane_bank_bench.sv
module ioport_lane_bank_bench;
  localparam int          NB  = 4;
  localparam int          NW  = 2;
  localparam int          CSW = 2 * NB + NW;
  localparam logic [15:0] BB  = 16'h0040;
  localparam logic [15:0] WB  = 16'h0080;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [15:0]    addr = '0;
  logic           bhe_n = 1'b1;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [15:0]    wdata = '0;
  logic [15:0]    rdata;
  logic [CSW-1:0] cs;

  always #2 clk = ~clk;

  ioport_lane_bank #(.N_BYTE_PAIRS(NB), .N_WORD(NW), .BYTE_BASE(BB), .WORD_BASE(WB))
    u_ioport_lane_bank (.clk(clk), .rst_n(rst_n), .addr(addr), .bhe_n(bhe_n),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cs(cs));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  m_lo[NB];
  logic [7:0]  m_hi[NB];
  logic [15:0] m_w[NW];

  function automatic logic [CSW-1:0] exp_cs(logic [15:0] a, logic bn, logic acc);
    logic [CSW-1:0] r = '0;
    int off;
    if (!acc) return r;
    off = int'(a) - int'(BB);
    if (off >= 0 && off < 2 * NB) begin
      if (a[0] == 1'b0) r[off / 2] = 1'b1;
      if (bn == 1'b0) r[NB + off / 2] = 1'b1;
    end
    off = int'(a) - int'(WB);
    if (off >= 0 && off < 2 * NW && a[0] == 1'b0 && bn == 1'b0) r[2 * NB + off / 2] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(logic [15:0] a, logic bn, logic rd);
    logic [CSW-1:0] c = exp_cs(a, bn, rd);
    logic [15:0] r = '0;
    for (int k = 0; k < NB; k++) begin
      if (c[k]) r[7:0] = m_lo[k];
      if (c[NB + k]) r[15:8] = m_hi[k];
    end
    for (int k = 0; k < NW; k++) if (c[2 * NB + k]) r = m_w[k];
    return r;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(string req, logic [15:0] a, logic bn, logic wr, logic rd, logic [15:0] wd);
    logic [CSW-1:0] ce;
    @(negedge clk);
    addr = a; bhe_n = bn; wr_en = wr; rd_en = rd; wdata = wd;
    #1;
    check(req, "cs", 32'(cs), 32'(exp_cs(a, bn, rd | wr)));
    check(req, "rdata", 32'(rdata), 32'(exp_rd(a, bn, rd)));
    @(posedge clk);
    if (wr) begin
      ce = exp_cs(a, bn, 1'b1);
      for (int k = 0; k < NB; k++) begin
        if (ce[k]) m_lo[k] = wd[7:0];
        if (ce[NB + k]) m_hi[k] = wd[15:8];
      end
      for (int k = 0; k < NW; k++) if (ce[2 * NB + k]) m_w[k] = wd;
    end
  endtask

  task automatic rd_word(string req, logic [15:0] a);
    cyc(req, a, 1'b0, 1'b0, 1'b1, 16'h0);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NB; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
    for (int k = 0; k < NW; k++) m_w[k] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R6: reset state of every port
    for (int k = 0; k < NB; k++) rd_word("R6", BB + 16'(2 * k));
    for (int k = 0; k < NW; k++) rd_word("R6", WB + 16'(2 * k));

    // R1: low-lane byte write, read pair back as word
    cyc("R1", BB, 1'b1, 1'b1, 1'b0, 16'hA5C3);
    rd_word("R1", BB);
    check("R1", "even port alone", 32'(m_lo[0]), 32'h00C3);
    // R2: high-lane byte write at odd address
    cyc("R2", BB + 16'd1, 1'b0, 1'b1, 1'b0, 16'h7E11);
    rd_word("R2", BB);
    // R2: odd-address "word" write touches only the odd port
    cyc("R2", BB + 16'd3, 1'b0, 1'b1, 1'b0, 16'h9922);
    rd_word("R2", BB + 16'd2);
    // R3: word write to a pair
    cyc("R3", BB + 16'd4, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    cyc("R3", BB + 16'd4, 1'b1, 1'b0, 1'b1, 16'h0);
    cyc("R3", BB + 16'd5, 1'b0, 1'b0, 1'b1, 16'h0);
    // R4: word port full write, then byte write ignored
    cyc("R4", WB + 16'd2, 1'b0, 1'b1, 1'b0, 16'h1234);
    cyc("R4", WB + 16'd2, 1'b1, 1'b1, 1'b0, 16'hFFFF);
    cyc("R4", WB + 16'd3, 1'b0, 1'b1, 1'b0, 16'hFFFF);
    rd_word("R4", WB + 16'd2);
    check("R4", "word port kept", 32'(m_w[1]), 32'h1234);
    // R5: invalid cycle
    cyc("R5", BB + 16'd1, 1'b1, 1'b1, 1'b1, 16'h5555);
    rd_word("R5", BB);
    // R7: neighbours unchanged after byte writes
    cyc("R7", BB + 16'd6, 1'b1, 1'b1, 1'b0, 16'h00AA);
    rd_word("R7", BB + 16'd6);
    // R8: unmatched address and idle read strobe
    rd_word("R8", 16'h1230);
    cyc("R8", BB, 1'b0, 1'b0, 1'b0, 16'h0);
    // R9: random mix, cs layout and groups
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      int sel = int'($urandom_range(0, 9));
      if (sel < 5)      a = BB + 16'($urandom_range(0, 2 * NB + 1));
      else if (sel < 8) a = WB + 16'($urandom_range(0, 2 * NW + 1));
      else              a = 16'($urandom);
      cyc("R9", a, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
    end
    // R6: reset clears after traffic
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    for (int k = 0; k < NB; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
    for (int k = 0; k < NW; k++) m_w[k] = '0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NB; k++) rd_word("R6", BB + 16'(2 * k));
    for (int k = 0; k < NW; k++) rd_word("R6", WB + 16'(2 * k));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule